// File: doc/BRIEF.md
# Multi-Cycle Shared-ALU Processor Datapath

This block is the 32-bit datapath of a small load/store processor that runs each instruction over several clock cycles. It handles register-register arithmetic (add, subtract, and, or, signed set-less-than), word load, word store, branch-if-equal and absolute jump. One memory port carries both the instruction fetch and the data access. One ALU does all the arithmetic, including the PC increment and the branch target. Holding registers carry values from one cycle to the next: the instruction register, the memory data register, the two operand latches and the ALU result latch.

An external sequencer drives the per-cycle select and enable inputs. It reads back the opcode and function fields of the latched instruction and the ALU zero flag. The memory itself sits outside the block. The block presents an address and write data, and it takes read data back combinationally in the same cycle. The sequencer asserts the memory write strobe directly.

Top module: `mc_datapath`

## Requirements
- R1: After reset the PC, the instruction register and all general registers are zero. The first memory address presented with `addr_sel`=0 is 0, and `opcode`/`funct` read 0.
- R2: In a fetch cycle the controls are `ir_wr`=1, `pc_wr`=1, `src_b_sel`=1 (constant 4), `alu_op`=0 (add), `pc_src`=0 (ALU output) and `addr_sel`=0. `mem_addr` shows the PC. After the edge, `opcode` equals bits 31:26 of the fetched word, `funct` equals bits 5:0, and the PC has advanced by 4. With `ir_wr`=0 the instruction register keeps its value.
- R3: Every cycle latches register[bits 25:21] into operand A and register[bits 20:16] into operand B. A decode cycle (`src_a_sel`=0, `src_b_sel`=3) latches PC + (sign-extended bits 15:0 shifted left by 2) into the ALU result latch.
- R4: With `alu_op`=2 the function field selects the ALU operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). `alu_op`=0 forces add and `alu_op`=1 forces subtract.
- R5: With `reg_wr`=1, `reg_dst`=1 and `mem_to_reg`=0, the ALU result latch is written to register[bits 15:11] at the edge.
- R6: An address cycle (`src_a_sel`=1, `src_b_sel`=2) forms A + sign-extended bits 15:0. With `addr_sel`=1 that value appears on `mem_addr` in the next cycle, and `mem_wdata` carries operand B.
- R7: The memory data register captures `mem_rdata` every cycle. With `reg_wr`=1, `reg_dst`=0 and `mem_to_reg`=1 it is written to register[bits 20:16].
- R8: Register 0 always reads as zero. Writes to it have no effect.
- R9: With `pc_wr_cond`=1 and `pc_src`=1, the PC loads the ALU result latch only when the ALU zero flag is set. Otherwise the PC keeps its value.
- R10: With `pc_wr`=1 and `pc_src`=2, the PC loads {PC[31:28], bits 25:0 of the instruction, 2'b00}.
- R11: The PC changes only when `pc_wr`=1, or when `pc_wr_cond`=1 and the zero flag is set.
- R12: `zero` is 1 exactly when the current ALU result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load gated by the zero flag |
| addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result latch |
| ir_wr | input | 1 | Instruction register load |
| reg_wr | input | 1 | Register file write enable |
| reg_dst | input | 1 | Write index: 0 bits 20:16, 1 bits 15:11 |
| mem_to_reg | input | 1 | Write data: 0 ALU result latch, 1 memory data register |
| src_a_sel | input | 1 | ALU input A: 0 PC, 1 operand A |
| src_b_sel | input | 2 | ALU input B: 0 operand B, 1 four, 2 immediate, 3 immediate shifted by 2 |
| alu_op | input | 2 | 0 add, 1 subtract, 2 by function field |
| pc_src | input | 2 | PC source: 0 ALU output, 1 ALU result latch, 2 jump target |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (operand B) |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU result is zero |

## Verification
Random register contents, filled through loads from a random data region, go through randomly chosen arithmetic, load, store, branch and jump sequences. Each result surfaces on the store data or on the next fetch address. Directed cases set a negative operand against a positive one, so that signed and unsigned comparison give different answers. Base-plus-negative-offset stores tell apart a correct sign extension from a zero extension. Writes and loads aimed at register 0 show whether its storage is truly inert. Idle cycles that have the jump source selected but no enable, together with unequal branches, show whether the PC moves without permission.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int W = 32;

  typedef enum logic [2:0] {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT} alu_fn_e;

  localparam logic [1:0] OP_ADD   = 2'd0;
  localparam logic [1:0] OP_SUB   = 2'd1;
  localparam logic [1:0] OP_FUNCT = 2'd2;

  localparam logic [1:0] SB_REG  = 2'd0;
  localparam logic [1:0] SB_FOUR = 2'd1;
  localparam logic [1:0] SB_IMM  = 2'd2;
  localparam logic [1:0] SB_IMM4 = 2'd3;

  localparam logic [1:0] PS_ALU = 2'd0;
  localparam logic [1:0] PS_OUT = 2'd1;
  localparam logic [1:0] PS_JMP = 2'd2;

  // R4: operation selection
  function automatic alu_fn_e alu_decode(logic [1:0] op, logic [5:0] fn);
    alu_fn_e r;
    r = FN_ADD;
    if (op == OP_SUB) r = FN_SUB;
    else if (op == OP_FUNCT) begin
      case (fn)
        6'h22:   r = FN_SUB;
        6'h24:   r = FN_AND;
        6'h25:   r = FN_OR;
        6'h2A:   r = FN_SLT;
        default: r = FN_ADD;
      endcase
    end
    return r;
  endfunction

  function automatic logic [W-1:0] sext16(logic [15:0] v);
    return {{(W-16){v[15]}}, v};
  endfunction

  function automatic logic [W-1:0] alu_calc(alu_fn_e f, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    case (f)
      FN_SUB:  r = a - b;
      FN_AND:  r = a & b;
      FN_OR:   r = a | b;
      FN_SLT:  r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction

  // R10: region-relative jump
  function automatic logic [W-1:0] jump_target(logic [W-1:0] pc, logic [W-1:0] ir);
    return {pc[W-1:W-4], ir[25:0], 2'b00};
  endfunction
endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] wa,
  input  logic          we,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  logic [DW-1:0] regs [NREG];

  // R8: entry 0 has no storage
  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            regs[g] <= '0;
      else if (we && wa == AW'(g))           regs[g] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
(
  input  logic [1:0]   alu_op,
  input  logic [5:0]   fn_field,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         zero
);
  assign fn   = alu_decode(alu_op, fn_field);
  assign res  = alu_calc(fn, a, b);
  assign zero = (res == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_wr,
  input  logic        pc_wr_cond,
  input  logic        addr_sel,
  input  logic        ir_wr,
  input  logic        reg_wr,
  input  logic        reg_dst,
  input  logic        mem_to_reg,
  input  logic        src_a_sel,
  input  logic [1:0]  src_b_sel,
  input  logic [1:0]  alu_op,
  input  logic [1:0]  pc_src,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero
);
  localparam int NREG = 32;
  localparam int AW   = $clog2(NREG);

  logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [W-1:0] rf_a, rf_b, rf_wd, src_a, src_b, alu_res, pc_next, imm_ext;
  logic [AW-1:0] rf_wa;
  alu_fn_e      alu_fn;
  logic         pc_load;

  assign imm_ext = sext16(ir_q[15:0]);

  // operand selection
  assign src_a = src_a_sel ? a_q : pc_q;
  always_comb begin
    case (src_b_sel)
      SB_REG:  src_b = b_q;
      SB_FOUR: src_b = W'(4);
      SB_IMM:  src_b = imm_ext;
      default: src_b = imm_ext << 2;
    endcase
  end

  mcd_alu u_alu (
    .alu_op  (alu_op),
    .fn_field(ir_q[5:0]),
    .a       (src_a),
    .b       (src_b),
    .fn      (alu_fn),
    .res     (alu_res),
    .zero    (zero)
  );

  // write-back path
  assign rf_wa = reg_dst ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = mem_to_reg ? mdr_q : aluout_q;

  mcd_regfile #(.NREG(NREG), .DW(W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(ir_q[25:21]), .ra2(ir_q[20:16]),
    .wa(rf_wa), .we(reg_wr), .wd(rf_wd),
    .rd1(rf_a), .rd2(rf_b)
  );

  // PC source and load condition
  always_comb begin
    case (pc_src)
      PS_OUT:  pc_next = aluout_q;
      PS_JMP:  pc_next = jump_target(pc_q, ir_q);
      default: pc_next = alu_res;
    endcase
  end
  assign pc_load = pc_wr | (pc_wr_cond & zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_load) pc_q <= pc_next;
      if (ir_wr)   ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rf_a;
      b_q      <= rf_b;
      aluout_q <= alu_res;
    end
  end

  assign mem_addr  = addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q)); // R11
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> $stable(ir_q)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == PS_ALU && !src_a_sel && src_b_sel == SB_FOUR && alu_op == OP_ADD)
    |=> pc_q == $past(pc_q) + 32'd4); // R2
  AST_BR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_cond && !pc_wr && zero && pc_src == PS_OUT) |=> pc_q == $past(aluout_q)); // R9
  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == PS_JMP)
    |=> (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28]))); // R10
  AST_SLT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    alu_fn == FN_SLT |-> alu_res[W-1:1] == '0); // R4
  AST_SUB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == FN_SUB && src_a == src_b) |-> zero); // R12
endmodule

// File: tb/sim_mc_datapath.sv
module sim_mc_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_wr, pc_wr_cond, addr_sel, ir_wr, reg_wr, reg_dst, mem_to_reg, src_a_sel;
  logic [1:0] src_b_sel, alu_op, pc_src;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0]  opcode, funct;
  logic        zero;

  logic [31:0] mem [256];
  logic [31:0] m_r [32];
  logic [31:0] m_pc;
  string       next_tag;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  mc_datapath u0 (.*);

  function automatic logic [31:0] sx(logic [15:0] v);
    logic [31:0] r = {16'h0000, v};
    if (v[15]) r = r | 32'hFFFF_0000;
    return r;
  endfunction

  function automatic logic [31:0] ref_op(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    if (f == 6'h22) return a + ~b + 32'd1;
    if (f == 6'h24) return a & b;
    if (f == 6'h25) return a | b;
    if (f == 6'h2A) begin
      if (a[31] != b[31]) return {31'd0, a[31]};
      return {31'd0, (a < b)};
    end
    return a + b;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_clear();
    pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; ir_wr = 0; reg_wr = 0; reg_dst = 0;
    mem_to_reg = 0; src_a_sel = 0; src_b_sel = 0; alu_op = 0; pc_src = 0;
  endtask

  task automatic clock_it();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fetch(logic [31:0] instr);
    mem[m_pc[9:2]] = instr;
    ctl_clear(); ir_wr = 1; pc_wr = 1; src_b_sel = 2'd1;
    #2;
    check(mem_addr == m_pc, next_tag, mem_addr, m_pc);
    next_tag = "R2";
    clock_it();
    check(opcode == instr[31:26] && funct == instr[5:0], "R2",
          {20'd0, opcode, funct}, {20'd0, instr[31:26], instr[5:0]});
    m_pc = m_pc + 32'd4;
  endtask

  task automatic decode();
    ctl_clear(); src_b_sel = 2'd3;
    clock_it();
  endtask

  task automatic addr_calc();
    ctl_clear(); src_a_sel = 1; src_b_sel = 2'd2;
    clock_it();
  endtask

  task automatic do_rtype(int rs, int rt, int rd, logic [5:0] f);
    logic [31:0] v;
    v = ref_op(f, m_r[rs], m_r[rt]);
    fetch({6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, f});
    decode();
    ctl_clear(); src_a_sel = 1; alu_op = 2'd2;
    clock_it();
    ctl_clear(); reg_dst = 1; reg_wr = 1;
    clock_it();
    if (rd != 0) m_r[rd] = v;
  endtask

  task automatic do_lw(int base, int rt, logic [15:0] imm);
    logic [31:0] ea, v;
    ea = m_r[base] + sx(imm);
    fetch({6'h23, 5'(base), 5'(rt), imm});
    decode();
    addr_calc();
    ctl_clear(); addr_sel = 1; src_a_sel = 1; src_b_sel = 2'd2;
    #2;
    check(mem_addr == ea, "R6", mem_addr, ea);
    v = mem[ea[9:2]];
    clock_it();
    ctl_clear(); mem_to_reg = 1; reg_wr = 1;
    clock_it();
    if (rt != 0) m_r[rt] = v;
  endtask

  task automatic do_sw(int base, int rt, logic [15:0] imm, string tag);
    logic [31:0] ea;
    ea = m_r[base] + sx(imm);
    fetch({6'h2B, 5'(base), 5'(rt), imm});
    decode();
    addr_calc();
    ctl_clear(); addr_sel = 1; src_a_sel = 1; src_b_sel = 2'd2;
    #2;
    check(mem_addr == ea, "R6", mem_addr, ea);
    check(mem_wdata == m_r[rt], tag, mem_wdata, m_r[rt]);
    mem[mem_addr[9:2]] = mem_wdata;
    clock_it();
  endtask

  task automatic do_beq(int rs, int rt, logic [15:0] imm);
    bit eq;
    eq = (m_r[rs] == m_r[rt]);
    fetch({6'h04, 5'(rs), 5'(rt), imm});
    decode();
    ctl_clear(); src_a_sel = 1; alu_op = 2'd1; pc_wr_cond = 1; pc_src = 2'd1;
    #2;
    check(zero == eq, "R12", {31'd0, zero}, {31'd0, eq});
    clock_it();
    if (eq) m_pc = m_pc + (sx(imm) << 2);
    next_tag = eq ? "R9" : "R11";
  endtask

  task automatic do_j(logic [25:0] t);
    fetch({6'h02, t});
    decode();
    ctl_clear(); pc_wr = 1; pc_src = 2'd2;
    clock_it();
    m_pc = {m_pc[31:28], t, 2'b00};
    next_tag = "R10";
  endtask

  function automatic logic [15:0] data_off();
    return 16'(32'h200 + 4 * ($urandom % 128));
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    for (int i = 0; i < 32; i++) m_r[i] = '0;
    m_pc = '0;
    next_tag = "R1";
    ctl_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    check(opcode == 0 && funct == 0, "R1", {26'd0, opcode}, 32'd0);
    check(zero == 1'b1, "R1 zero after reset", {31'd0, zero}, 32'd1);

    // R8: writes aimed at register 0
    do_lw(0, 0, 16'h0204);
    do_sw(0, 0, 16'h0300, "R8");
    do_lw(0, 1, 16'h0208);
    do_lw(0, 2, 16'h020C);
    do_rtype(1, 2, 0, 6'h25);
    do_sw(0, 0, 16'h0304, "R8");

    // R4: signed compare with mixed signs
    mem[32'h210 >> 2] = 32'hFFFF_FFF0;
    mem[32'h214 >> 2] = 32'h0000_0005;
    do_lw(0, 3, 16'h0210);
    do_lw(0, 4, 16'h0214);
    do_rtype(3, 4, 5, 6'h2A);
    do_sw(0, 5, 16'h0308, "R4");
    do_rtype(4, 3, 6, 6'h2A);
    do_sw(0, 6, 16'h030C, "R4");

    // R6: base plus negative offset
    mem[32'h218 >> 2] = 32'h0000_0300;
    do_lw(0, 7, 16'h0218);
    do_sw(7, 4, 16'hFFC0, "R6");

    // R11: idle cycles with jump source selected but no enable
    ctl_clear(); pc_src = 2'd2; clock_it();
    ctl_clear(); pc_src = 2'd1; clock_it();
    next_tag = "R11";
    do_beq(3, 4, 16'h0003);

    for (int i = 0; i < 300; i++) begin
      int k, a, b, d;
      logic [5:0] fs [5];
      fs[0] = 6'h20; fs[1] = 6'h22; fs[2] = 6'h24; fs[3] = 6'h25; fs[4] = 6'h2A;
      if (m_pc >= 32'h1C0) do_j(26'(4 + ($urandom % 16)));
      k = $urandom % 5;
      a = $urandom % 32; b = $urandom % 32; d = $urandom % 32;
      case (k)
        0: begin
          do_rtype(a, b, d, fs[$urandom % 5]);
          do_sw(0, d, data_off(), (d == 0) ? "R8" : "R5");
        end
        1: begin
          do_lw(0, d, data_off());
          do_sw(0, d, data_off(), (d == 0) ? "R8" : "R7");
        end
        2: do_sw(0, a, data_off(), "R3");
        3: do_beq(a, ($urandom % 3 == 0) ? a : b, 16'($urandom % 8));
        default: do_j(26'(4 + ($urandom % 64)));
      endcase
    end
    fetch(32'd0);

    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule